// File: doc/BRIEF.md
# Floating-Point Issue Hazard Interlock

This block sits beside the decode stage of an in-order-issue pipeline whose execution units finish out of order. Four units are served: a one-stage integer unit, a four-stage pipelined FP adder, a seven-stage pipelined FP multiplier and a 24-cycle FP divider that accepts one operation at a time. Each cycle the decode stage presents the instruction it holds: its unit, an optional destination register and up to two optional source registers. The block then decides, with no clock delay, whether that instruction may leave decode. When it may not, the instruction stays in decode and a bubble goes into execute.

Three kinds of hazard are blocked. A structural hazard occurs when the divider is still occupied, or when the new instruction would arrive at the memory stage on the same edge as one already in flight. A read-after-write hazard occurs when a source register is still being computed inside an FP unit. A write-after-write hazard occurs when a shorter instruction would write its register before an older, longer one aimed at the same register. The bookkeeping has three parts. A write-back reservation shift register indexed by edges-until-memory-entry tracks every in-flight instruction. Each register carries a remaining-cycles marker. The divider occupancy is a small state machine with three states:

- `DV_IDLE`: no divide is in flight.
- `DV_BUSY`: a divide has two or more execute cycles left.
- `DV_LAST`: a divide is in its final execute cycle.

Its transitions are `IDLE->BUSY` when a divide issues, `BUSY->LAST` when the counter reaches two, `LAST->BUSY` when a new divide issues in that cycle, and `LAST->IDLE` otherwise. Operand bypassing from the memory and write-back stages is handled elsewhere.

Top module: `fpil_issue_interlock`

## Requirements
- R1: `issue` is `id_valid` and not `stall`. While `id_valid` is 0, `stall` and every cause output are 0.
- R2: Unit codes are 0 integer (1 execute stage), 1 FP add (4), 2 FP multiply (7) and 3 FP divide (24). An instruction of latency L issued on an edge enters the memory stage L+1 edges later.
- R3: A divide in decode stalls, with `stall_unit_busy` high, while an earlier divide has two or more execute cycles left. A divide presented right after another therefore stalls exactly 23 cycles. This is the only occupancy stall.
- R4: An instruction of latency L stalls, with `stall_wb_slot` high, when an in-flight instruction will enter the memory stage exactly L+1 edges from now. This applies whatever the two instructions' registers are.
- R5: An enabled source register that matches the destination of an instruction still executing in an FP unit (add, multiply or divide) causes a stall with `stall_raw` high. Destinations written by the integer unit never cause such a stall.
- R6: An instruction of latency L with an enabled destination stalls, with `stall_waw` high, while an older FP-unit instruction writing the same register still has more than L execute cycles to go. It is released once the older one will reach the memory stage first.
- R7: A destination that matches a source register of an older in-flight instruction causes no stall.
- R8: A source or destination field whose enable bit is 0 takes part in no hazard check.
- R9: The four cause outputs each report their own hazard in the same cycle, and `stall` is their OR gated by `id_valid`.
- R10: Reset clears the divider state, all write-back reservations and all register markers, so an instruction presented after reset issues at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_valid | input | 1 | Decode holds an instruction |
| id_unit | input | 2 | Unit code (0 int, 1 add, 2 mul, 3 div) |
| id_dst_en | input | 1 | Instruction writes a register |
| id_dst | input | 5 | Destination register |
| id_srca_en | input | 1 | First source is read |
| id_srca | input | 5 | First source register |
| id_srcb_en | input | 1 | Second source is read |
| id_srcb | input | 5 | Second source register |
| stall | output | 1 | Hold the instruction in decode, bubble into execute |
| issue | output | 1 | Instruction leaves decode on the next edge |
| stall_unit_busy | output | 1 | Divider occupied |
| stall_wb_slot | output | 1 | Memory-stage arrival collides |
| stall_raw | output | 1 | Source still being produced |
| stall_waw | output | 1 | Write would overtake an older write |

## Verification
The bench sweeps every pair of units at several issue gaps, with the two instructions independent, reading-after-writing, or writing the same register. For each cycle it computes the expected cause bits from the remaining latency of the first instruction. A design that is off by one in the divider release would stall a back-to-back divide 22 or 24 cycles instead of 23. A reservation ring indexed at L instead of L+1 would flag the wrong arrival cycle, for example multiply followed two cycles later by add. A WAW compare using "at least L" instead of "more than L" would hold a subtract one cycle too long behind a divide. Further directed cases cover a WAR pair, disabled fields, integer-unit writers, an idle decode while a hazard is pending, and reset in mid-flight.

// File: rtl/fpil_pkg.sv
package fpil_pkg;

    typedef enum logic [1:0] {
        U_INT = 2'd0,
        U_ADD = 2'd1,
        U_MUL = 2'd2,
        U_DIV = 2'd3
    } unit_e;

    typedef enum logic [1:0] {
        DV_IDLE = 2'd0,
        DV_BUSY = 2'd1,
        DV_LAST = 2'd2
    } div_state_e;

    typedef struct packed {
        logic busy;
        logic slot;
        logic raw;
        logic waw;
    } cause_t;

endpackage

// File: rtl/fpil_div_track.sv
module fpil_div_track
    import fpil_pkg::*;
#(
    parameter int DIV_LAT = 24,
    parameter int LW      = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);

    div_state_e        state, state_nx;
    logic [LW-1:0]     cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= DV_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)         cnt <= '0;
        else if (start)     cnt <= LW'(DIV_LAT);
        else if (cnt != '0) cnt <= cnt - 1'b1;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            DV_IDLE: if (start) state_nx = DV_BUSY;
            DV_BUSY: if (cnt == LW'(2)) state_nx = DV_LAST;
            DV_LAST: state_nx = start ? DV_BUSY : DV_IDLE;
            default: state_nx = DV_IDLE;
        endcase
    end

    always_comb begin
        busy = (state == DV_BUSY);
    end

    // R3: the final-cycle state agrees with the counter
    a_r3_last_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == DV_LAST) |-> (cnt == LW'(1)));

    // R3: no divide starts while the unit is occupied
    a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        (state == DV_BUSY) |-> !start);

endmodule

// File: rtl/fpil_slot_ring.sv
module fpil_slot_ring #(
    parameter int MAXL = 24,
    parameter int LW   = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          book,
    input  logic [LW-1:0] lat,
    output logic          clash
);

    logic [MAXL:1]   slots;
    logic [MAXL+1:0] ext;
    logic [MAXL:1]   slots_nx;

    always_comb begin
        ext   = {1'b0, slots, 1'b0};
        clash = ext[lat + 1'b1];
    end

    always_comb begin
        slots_nx = slots >> 1;
        if (book) slots_nx[lat] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) slots <= '0;
        else        slots <= slots_nx;
    end

    // R4: a reservation is never placed on an arrival edge already taken
    a_r4_single_booking: assert property (@(posedge clk) disable iff (!rst_n)
        book |-> !ext[lat + 1'b1]);

    // R4: a booking shows up at its latency on the next cycle
    a_r4_booked: assert property (@(posedge clk) disable iff (!rst_n)
        book |=> slots[$past(lat)]);

endmodule

// File: rtl/fpil_pend_track.sv
module fpil_pend_track #(
    parameter int NREG = 32,
    parameter int RW   = 5,
    parameter int LW   = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mark,
    input  logic [RW-1:0] mark_reg,
    input  logic [LW-1:0] mark_lat,
    input  logic [RW-1:0] rd_a,
    input  logic [RW-1:0] rd_b,
    input  logic [RW-1:0] rd_d,
    output logic [LW-1:0] left_a,
    output logic [LW-1:0] left_b,
    output logic [LW-1:0] left_d
);

    logic [LW-1:0] pend [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)                              pend[g] <= '0;
            else if (mark && (mark_reg == RW'(g)))   pend[g] <= mark_lat;
            else if (pend[g] != '0)                  pend[g] <= pend[g] - 1'b1;
        end
    end

    always_comb begin
        left_a = pend[rd_a];
        left_b = pend[rd_b];
        left_d = pend[rd_d];
    end

    // R6: an issued FP write loads its marker with its latency
    a_r6_marker_load: assert property (@(posedge clk) disable iff (!rst_n)
        mark |=> (pend[$past(mark_reg)] == $past(mark_lat)));

endmodule

// File: rtl/fpil_issue_interlock.sv
module fpil_issue_interlock
    import fpil_pkg::*;
#(
    parameter int NREG    = 32,
    parameter int INT_LAT = 1,
    parameter int ADD_LAT = 4,
    parameter int MUL_LAT = 7,
    parameter int DIV_LAT = 24
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       id_valid,
    input  logic [1:0] id_unit,
    input  logic       id_dst_en,
    input  logic [4:0] id_dst,
    input  logic       id_srca_en,
    input  logic [4:0] id_srca,
    input  logic       id_srcb_en,
    input  logic [4:0] id_srcb,
    output logic       stall,
    output logic       issue,
    output logic       stall_unit_busy,
    output logic       stall_wb_slot,
    output logic       stall_raw,
    output logic       stall_waw
);

    localparam int RW   = 5;
    localparam int M1   = (MUL_LAT > ADD_LAT) ? MUL_LAT : ADD_LAT;
    localparam int M2   = (M1 > INT_LAT) ? M1 : INT_LAT;
    localparam int MAXL = (DIV_LAT > M2) ? DIV_LAT : M2;
    localparam int LW   = $clog2(MAXL + 2);

    unit_e         unit;
    logic [LW-1:0] lat;
    logic          fp_unit;
    logic          div_busy;
    logic          slot_clash;
    logic [LW-1:0] left_a, left_b, left_d;
    cause_t        cause;

    always_comb begin
        unit = unit_e'(id_unit);
        unique case (unit)
            U_INT:   lat = LW'(INT_LAT);
            U_ADD:   lat = LW'(ADD_LAT);
            U_MUL:   lat = LW'(MUL_LAT);
            U_DIV:   lat = LW'(DIV_LAT);
            default: lat = LW'(INT_LAT);
        endcase
        fp_unit = (unit != U_INT);
    end

    fpil_div_track #(.DIV_LAT(DIV_LAT), .LW(LW)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (issue && (unit == U_DIV)),
        .busy  (div_busy)
    );

    fpil_slot_ring #(.MAXL(MAXL), .LW(LW)) u_ring (
        .clk   (clk),
        .rst_n (rst_n),
        .book  (issue),
        .lat   (lat),
        .clash (slot_clash)
    );

    fpil_pend_track #(.NREG(NREG), .RW(RW), .LW(LW)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .mark     (issue && fp_unit && id_dst_en),
        .mark_reg (id_dst),
        .mark_lat (lat),
        .rd_a     (id_srca),
        .rd_b     (id_srcb),
        .rd_d     (id_dst),
        .left_a   (left_a),
        .left_b   (left_b),
        .left_d   (left_d)
    );

    always_comb begin
        cause.busy = id_valid && (unit == U_DIV) && div_busy;
        cause.slot = id_valid && slot_clash;
        cause.raw  = id_valid && ((id_srca_en && (left_a != '0)) ||
                                  (id_srcb_en && (left_b != '0)));
        cause.waw  = id_valid && id_dst_en && (left_d > lat);
    end

    always_comb begin
        stall           = |cause;
        issue           = id_valid && !stall;
        stall_unit_busy = cause.busy;
        stall_wb_slot   = cause.slot;
        stall_raw       = cause.raw;
        stall_waw       = cause.waw;
    end

    // R5: a pending FP result read as a source blocks issue
    a_r5_raw_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (id_valid && id_srca_en && (left_a != '0)) |-> !issue);

    // R3: a divide never leaves decode while the divider is occupied
    a_r3_div_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (id_valid && (unit == U_DIV) && div_busy) |-> !issue);

    // R1: nothing stalls without an instruction
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !id_valid |-> !(stall_unit_busy || stall_wb_slot || stall_raw || stall_waw));

endmodule

// File: tb/fpil_issue_interlock_test.sv
`timescale 1ns/100ps
module fpil_issue_interlock_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       id_valid = 1'b0;
    logic [1:0] id_unit = 2'd0;
    logic       id_dst_en = 1'b0;
    logic [4:0] id_dst = 5'd0;
    logic       id_srca_en = 1'b0;
    logic [4:0] id_srca = 5'd0;
    logic       id_srcb_en = 1'b0;
    logic [4:0] id_srcb = 5'd0;
    logic       stall, issue, stall_unit_busy, stall_wb_slot, stall_raw, stall_waw;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    fpil_issue_interlock uut (
        .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_unit(id_unit),
        .id_dst_en(id_dst_en), .id_dst(id_dst),
        .id_srca_en(id_srca_en), .id_srca(id_srca),
        .id_srcb_en(id_srcb_en), .id_srcb(id_srcb),
        .stall(stall), .issue(issue),
        .stall_unit_busy(stall_unit_busy), .stall_wb_slot(stall_wb_slot),
        .stall_raw(stall_raw), .stall_waw(stall_waw)
    );

    function automatic int lat_of(int u);
        case (u)
            0: return 1;
            1: return 4;
            2: return 7;
            default: return 24;
        endcase
    endfunction

    // expected {busy, slot, raw, waw}; dep 0 none, 1 raw, 2 waw
    function automatic logic [3:0] exp_flags(int ua, int ub, int dep, int d);
        int r  = lat_of(ua) - d;
        int lb = lat_of(ub);
        logic b, s, rw, ww;
        b  = (ua == 3) && (ub == 3) && (r > 1);
        s  = (r >= 1) && (r == lb + 1);
        rw = (dep == 1) && (ua != 0) && (r >= 1);
        ww = (dep == 2) && (ua != 0) && (r > lb);
        return {b, s, rw, ww};
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drive(input bit v, input int u, input bit de, input int dr,
                         input bit ae, input int ar, input bit be, input int br);
        id_valid = v; id_unit = 2'(u); id_dst_en = de; id_dst = 5'(dr);
        id_srca_en = ae; id_srca = 5'(ar); id_srcb_en = be; id_srcb = 5'(br);
    endtask

    function automatic int flags_now();
        return {28'd0, stall_unit_busy, stall_wb_slot, stall_raw, stall_waw};
    endfunction

    task automatic idle(input int n);
        drive(0, 0, 0, 0, 0, 0, 0, 0);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_pair(input int ua, input int ub, input int dep, input int g, input string tag);
        int d;
        logic [3:0] e;
        @(negedge clk);
        drive(1, ua, 1, 3, 0, 0, 0, 0);
        #1 chk(issue === 1'b1 && stall === 1'b0, {tag, " R1 first issues"}, int'(issue), 1);
        @(negedge clk);
        drive(0, 0, 0, 0, 0, 0, 0, 0);
        repeat (g) @(negedge clk);
        case (dep)
            0: drive(1, ub, 1, 7, 1, 9, 0, 0);
            1: drive(1, ub, 1, 7, 1, 3, 0, 0);
            default: drive(1, ub, 1, 3, 0, 0, 0, 0);
        endcase
        d = g;
        for (int k = 0; k < 60; k++) begin
            #1;
            e = exp_flags(ua, ub, dep, d);
            chk(flags_now() == int'(e) && stall === (|e) && issue === !(|e),
                {tag, " R9 causes"}, flags_now(), int'(e));
            if (!(|e)) break;
            @(negedge clk);
            d++;
        end
        @(negedge clk);
        idle(30);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 chk(stall === 1'b0 && issue === 1'b0, "R10 reset outputs", int'(stall), 0);
        rst_n = 1'b1;
        @(negedge clk);
        #1 chk(stall === 1'b0 && issue === 1'b0, "R1 idle after reset", int'(issue), 0);

        // sweep every unit pair, dependency kind and gap
        for (int ua = 0; ua < 4; ua++)
            for (int ub = 0; ub < 4; ub++)
                for (int dep = 0; dep < 3; dep++)
                    for (int gi = 0; gi < 3; gi++) begin
                        string tg;
                        if (dep == 1)                  tg = "R5";
                        else if (dep == 2)             tg = "R6";
                        else if (ua == 3 && ub == 3)   tg = "R3";
                        else                           tg = "R2 R4";
                        run_pair(ua, ub, dep, (gi == 0) ? 0 : (gi == 1 ? 2 : 5), tg);
                    end

        // R7: write to a register an older multiply still reads
        @(negedge clk); drive(1, 2, 1, 3, 1, 8, 0, 0);
        @(negedge clk); drive(1, 1, 1, 8, 0, 0, 0, 0);
        #1 chk(issue === 1'b1, "R7 WAR no stall", int'(issue), 1);
        @(negedge clk); idle(30);

        // R8: disabled source and destination fields are ignored
        @(negedge clk); drive(1, 2, 1, 3, 0, 0, 0, 0);
        @(negedge clk); drive(1, 1, 0, 3, 0, 3, 0, 3);
        #1 chk(issue === 1'b1 && stall_raw === 1'b0 && stall_waw === 1'b0,
               "R8 disabled fields", flags_now(), 0);
        @(negedge clk); idle(30);

        // R5: second source port also checked
        @(negedge clk); drive(1, 2, 1, 11, 0, 0, 0, 0);
        @(negedge clk); drive(1, 0, 0, 0, 0, 0, 1, 11);
        #1 chk(stall_raw === 1'b1 && stall === 1'b1, "R5 second source", int'(stall_raw), 1);
        @(negedge clk); idle(30);

        // R5: integer-unit destination never blocks a reader
        @(negedge clk); drive(1, 0, 1, 12, 0, 0, 0, 0);
        @(negedge clk); drive(1, 1, 1, 13, 1, 12, 1, 12);
        #1 chk(issue === 1'b1, "R5 integer writer", int'(issue), 1);
        @(negedge clk); idle(30);

        // R1: pending divide hazard, empty decode
        @(negedge clk); drive(1, 3, 1, 4, 0, 0, 0, 0);
        @(negedge clk); drive(0, 3, 1, 4, 1, 4, 0, 0);
        #1 chk(stall === 1'b0 && issue === 1'b0 && flags_now() == 0,
               "R1 idle with hazard", flags_now(), 0);

        // R10: reset in mid-flight clears divider, ring and markers
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        drive(1, 3, 1, 4, 1, 4, 0, 0);
        #1 chk(issue === 1'b1 && stall === 1'b0, "R10 reset clears state", flags_now(), 0);
        @(negedge clk); idle(30);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule